// File: doc/BRIEF.md
# Ancillary VBI Data Packet Inserter

This block sits in the digital video output path and places data bytes recovered from vertical-blanking lines into the 10-bit output stream as ancillary data packets. A packet starts on the first horizontal-blanking word after a line's end-of-active-video code. The block's input `eav_end` marks that word. Words outside a packet pass through with one register of latency.

Two 16-bit enable masks pick the lines that carry packets, one mask for each field parity. Mask bit 0 belongs to line `FIRST_LINE`, and each higher bit belongs to the next line. A payload of 2 or 4 bytes is packed either one nibble per word or one byte per word. Every header word and every nibble word carries an even-parity bit and its inverse. A 9-bit checksum word closes the packet.

Top module: `anc_vbi_inserter`

## Requirements
- R1: Outside a packet, `vid_out` equals the `vid_in` of the previous cycle.
- R2: A packet starts when `eav_end` is high on an enabled line. The clock edge that samples `eav_end` drives 0x000 onto `vid_out`, and the next five edges drive 0x3FF, 0x3FF, then the data identification word 0x140, then the line/type word, then the count word.
- R3: A line is enabled only when `FIRST_LINE <= line_num < FIRST_LINE+16` and the bit at index `line_num-FIRST_LINE` is 1 in the selected mask. The mask is `mask_odd` when `field_odd`=1 and `mask_even` otherwise. Any other line passes through unchanged.
- R4: When `data_valid`=0, no packet is inserted, even on an enabled line.
- R5: When `full_fmt`=0 (half-byte mode), each payload word holds one nibble in D[5:2] with D[7:6] and D[1:0] zero. Each byte is sent low nibble first, starting from `data_bytes[7:0]`.
- R6: When `full_fmt`=1 (full-byte mode), each payload word holds one byte in D[9:2] with D[1:0]=0, starting from `data_bytes[7:0]`.
- R7: When `wide_sel`=1 the payload uses 4 bytes, and otherwise it uses the 2 bytes `data_bytes[15:0]`. The number of payload words is the byte count in full-byte mode and twice the byte count in half-byte mode.
- R8: The DID, line/type, count and half-byte payload words set D[8] to the XOR of D[7:0] and set D[9] to the inverse of D[8].
- R9: The line/type word's D[7:0] holds {0, field_odd, wide_sel, full_fmt, line offset[3:0]}. The count word's D[7:0] holds the number of payload words.
- R10: The last packet word is a checksum. Its D[8:0] is the 9-bit sum of D[8:0] over all words from the DID through the last payload word, and its D[9] is the inverse of D[8].
- R11: While a packet is being emitted, `eav_end` and `vid_in` have no effect on the output.
- R12: While `rst` is high, `vid_out` is 0x000 and no packet is in progress.

Top module parameters: `LINE_W` is the width of `line_num` and `FIRST_LINE` is the line at mask bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 10 | Incoming video word |
| eav_end | input | 1 | High on the first blanking word after an end-of-active-video code |
| line_num | input | LINE_W | Current line number |
| field_odd | input | 1 | 1 in an odd field, 0 in an even field |
| mask_even | input | 16 | Per-line enables for even fields |
| mask_odd | input | 16 | Per-line enables for odd fields |
| data_valid | input | 1 | Recovered bytes for this line are valid |
| wide_sel | input | 1 | 1 selects 4 payload bytes, 0 selects 2 |
| full_fmt | input | 1 | 1 selects full-byte payload words, 0 selects half-byte words |
| data_bytes | input | 32 | Recovered bytes, byte 0 in bits 7:0 |
| vid_out | output | 10 | Outgoing video word |

## Verification
On every cycle the assertions check the following:
- the one-cycle passthrough when no packet is active;
- the 0x000 word that opens each packet;
- the parity pairing on the DID, line/type and count words;
- the inverted top bit of the checksum word;
- a packet that keeps advancing when `eav_end` arrives in its middle.

Only the bench scenarios can show the rest:
- the exact packet contents, including nibble and byte order and the checksum value;
- the choice of mask by field parity;
- the edges of the 16-line window;
- the effect of `data_valid`.

The bench checks these against a packet model built from the requirements.

// File: rtl/anc_pkg.sv
package anc_pkg;
    localparam int ANC_MASK_W    = 16;
    localparam int ANC_MAX_BYTES = 4;
    localparam int ANC_HDR_WORDS = 6;
    localparam int ANC_LEN_MAX   = ANC_HDR_WORDS + 2 * ANC_MAX_BYTES + 1;
    localparam int ANC_IDX_W     = $clog2(ANC_LEN_MAX);
    localparam int ANC_OFF_W     = $clog2(ANC_MASK_W);
    localparam int ANC_BSEL_W    = $clog2(ANC_MAX_BYTES);

    localparam logic [9:0] ANC_FLAG_LO = 10'h000;
    localparam logic [9:0] ANC_FLAG_HI = 10'h3FF;
    localparam logic [9:0] ANC_DID     = 10'h140;

    typedef struct packed {
        logic                         odd;
        logic                         wide;
        logic                         full;
        logic [ANC_OFF_W-1:0]         off;
        logic [8*ANC_MAX_BYTES-1:0]   bytes;
    } anc_ctx_t;

    // 8 data bits plus even parity and inverse parity
    function automatic logic [9:0] par_word(input logic [7:0] d);
        logic ep;
        ep = ^d;
        return {~ep, ep, d};
    endfunction

    function automatic logic [ANC_IDX_W-1:0] pay_words(input logic wide, input logic full);
        logic [ANC_IDX_W-1:0] nb;
        nb = wide ? ANC_IDX_W'(ANC_MAX_BYTES) : ANC_IDX_W'(ANC_MAX_BYTES / 2);
        return full ? nb : (nb << 1);
    endfunction
endpackage

// File: rtl/anc_line_gate.sv
module anc_line_gate
    import anc_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int FIRST_LINE = 10
) (
    input  logic [LINE_W-1:0]     line_num,
    input  logic                  field_odd,
    input  logic [ANC_MASK_W-1:0] mask_even,
    input  logic [ANC_MASK_W-1:0] mask_odd,
    input  logic                  data_valid,
    output logic                  hit,
    output logic [ANC_OFF_W-1:0]  off
);
    logic [LINE_W-1:0]     diff;
    logic                  in_win;
    logic [ANC_MASK_W-1:0] mask_sel;

    always_comb begin
        diff     = line_num - LINE_W'(FIRST_LINE);
        in_win   = (line_num >= LINE_W'(FIRST_LINE)) && (diff < LINE_W'(ANC_MASK_W));
        off      = diff[ANC_OFF_W-1:0];
        mask_sel = field_odd ? mask_odd : mask_even;
        hit      = in_win && mask_sel[off] && data_valid;
    end
endmodule

// File: rtl/anc_word_gen.sv
module anc_word_gen
    import anc_pkg::*;
(
    input  anc_ctx_t              ctx,
    input  logic [ANC_IDX_W-1:0]  idx,
    output logic [9:0]            word
);
    logic [ANC_BSEL_W:0]   k;
    logic [ANC_BSEL_W-1:0] bsel;
    logic [7:0]            byte_v;
    logic [3:0]            nib;

    always_comb begin
        k      = (ANC_BSEL_W + 1)'(idx - ANC_IDX_W'(ANC_HDR_WORDS));
        bsel   = ctx.full ? k[ANC_BSEL_W-1:0] : k[ANC_BSEL_W:1];
        byte_v = ctx.bytes[8*bsel +: 8];
        nib    = k[0] ? byte_v[7:4] : byte_v[3:0];
        case (idx)
            ANC_IDX_W'(0): word = ANC_FLAG_LO;
            ANC_IDX_W'(1): word = ANC_FLAG_HI;
            ANC_IDX_W'(2): word = ANC_FLAG_HI;
            ANC_IDX_W'(3): word = ANC_DID;
            ANC_IDX_W'(4): word = par_word(8'({ctx.odd, ctx.wide, ctx.full, ctx.off}));
            ANC_IDX_W'(5): word = par_word(8'(pay_words(ctx.wide, ctx.full)));
            default:       word = ctx.full ? {byte_v, 2'b00}
                                           : par_word({2'b00, nib, 2'b00});
        endcase
    end
endmodule

// File: rtl/anc_csum_acc.sv
module anc_csum_acc (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       add_en,
    input  logic [8:0] din,
    output logic [8:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clr)  sum <= '0;
        else if (add_en) sum <= sum + din;
    end
endmodule

// File: rtl/anc_vbi_inserter.sv
module anc_vbi_inserter
    import anc_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int FIRST_LINE = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [9:0]                   vid_in,
    input  logic                         eav_end,
    input  logic [LINE_W-1:0]            line_num,
    input  logic                         field_odd,
    input  logic [ANC_MASK_W-1:0]        mask_even,
    input  logic [ANC_MASK_W-1:0]        mask_odd,
    input  logic                         data_valid,
    input  logic                         wide_sel,
    input  logic                         full_fmt,
    input  logic [8*ANC_MAX_BYTES-1:0]   data_bytes,
    output logic [9:0]                   vid_out
);
    logic                  hit, start, busy;
    logic [ANC_OFF_W-1:0]  off;
    logic [ANC_IDX_W-1:0]  idx, last_idx;
    anc_ctx_t              ctx;
    logic [9:0]            gen_word;
    logic [8:0]            sum;
    logic                  add_en;

    anc_line_gate #(.LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE)) u_gate (
        .line_num(line_num), .field_odd(field_odd), .mask_even(mask_even),
        .mask_odd(mask_odd), .data_valid(data_valid), .hit(hit), .off(off)
    );

    anc_word_gen u_gen (.ctx(ctx), .idx(idx), .word(gen_word));

    assign start    = eav_end && hit && !busy;
    assign last_idx = ANC_IDX_W'(ANC_HDR_WORDS) + pay_words(ctx.wide, ctx.full);
    assign add_en   = busy && (idx >= ANC_IDX_W'(3)) && (idx < last_idx);

    anc_csum_acc u_csum (
        .clk(clk), .rst(rst), .clr(start), .add_en(add_en),
        .din(gen_word[8:0]), .sum(sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            ctx     <= '0;
            vid_out <= ANC_FLAG_LO;
        end else if (start) begin
            ctx     <= '{odd: field_odd, wide: wide_sel, full: full_fmt,
                         off: off, bytes: data_bytes};
            vid_out <= ANC_FLAG_LO;
            idx     <= ANC_IDX_W'(1);
            busy    <= 1'b1;
        end else if (busy) begin
            if (idx == last_idx) begin
                vid_out <= {~sum[8], sum};
                busy    <= 1'b0;
                idx     <= '0;
            end else begin
                vid_out <= gen_word;
                idx     <= idx + ANC_IDX_W'(1);
            end
        end else begin
            vid_out <= vid_in;
        end
    end
endmodule

// File: rtl/anc_vbi_inserter_chk.sv
module anc_vbi_inserter_chk
    import anc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [9:0]           vid_in,
    input logic                 eav_end,
    input logic [9:0]           vid_out,
    input logic                 busy,
    input logic                 start,
    input logic [ANC_IDX_W-1:0] idx,
    input logic [ANC_IDX_W-1:0] last_idx
);
    // R1
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (vid_out == $past(vid_in)));

    // R2
    flag_open_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (vid_out == 10'h000));

    // R8
    hdr_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (idx >= ANC_IDX_W'(3)) && (idx <= ANC_IDX_W'(5)))
        |=> ((vid_out[8] == ^vid_out[7:0]) && (vid_out[9] != vid_out[8])));

    // R10
    csum_top_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (idx == last_idx)) |=> (vid_out[9] != vid_out[8]));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && eav_end && (idx != last_idx)) |=> (busy && (idx == $past(idx) + ANC_IDX_W'(1))));

    // R12
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy);
endmodule

bind anc_vbi_inserter anc_vbi_inserter_chk u_chk (
    .clk(clk), .rst(rst), .vid_in(vid_in), .eav_end(eav_end), .vid_out(vid_out),
    .busy(busy), .start(start), .idx(idx), .last_idx(last_idx)
);

// File: tb/sim_anc_vbi_inserter.sv
module sim_anc_vbi_inserter;
    localparam int FL = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  vid_in = '0;
    logic        eav_end = 1'b0;
    logic [9:0]  line_num = '0;
    logic        field_odd = 1'b0;
    logic [15:0] mask_even = '0, mask_odd = '0;
    logic        data_valid = 1'b0, wide_sel = 1'b0, full_fmt = 1'b0;
    logic [31:0] data_bytes = '0;
    logic [9:0]  vid_out;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [9:0] ew [0:15];
    int elen;

    always #4 clk = ~clk;

    anc_vbi_inserter #(.LINE_W(10), .FIRST_LINE(FL)) u0 (
        .clk(clk), .rst(rst), .vid_in(vid_in), .eav_end(eav_end), .line_num(line_num),
        .field_odd(field_odd), .mask_even(mask_even), .mask_odd(mask_odd),
        .data_valid(data_valid), .wide_sel(wide_sel), .full_fmt(full_fmt),
        .data_bytes(data_bytes), .vid_out(vid_out)
    );

    task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] pw(input logic [7:0] d);
        return {~(^d), ^d, d};
    endfunction

    // Expected packet from R2, R5-R10
    task automatic build(input bit odd, input bit wide, input bit full,
                         input logic [3:0] off, input logic [31:0] by);
        int nb, np;
        logic [8:0] s;
        logic [7:0] b;
        nb = wide ? 4 : 2;
        np = full ? nb : 2 * nb;
        ew[0] = 10'h000; ew[1] = 10'h3FF; ew[2] = 10'h3FF; ew[3] = 10'h140;
        ew[4] = pw({1'b0, odd, wide, full, off});
        ew[5] = pw(8'(np));
        for (int k = 0; k < np; k++) begin
            if (full) begin
                b = by[8*k +: 8];
                ew[6+k] = {b, 2'b00};
            end else begin
                b = by[8*(k/2) +: 8];
                ew[6+k] = pw({2'b00, (k % 2 == 1) ? b[7:4] : b[3:0], 2'b00});
            end
        end
        s = '0;
        for (int k = 3; k < 6 + np; k++) s = s + ew[k][8:0];
        ew[6+np] = {~s[8], s};
        elen = 7 + np;
    endtask

    task automatic run_line(input int ln, input bit odd, input bit valid, input bit wide,
                            input bit full, input logic [31:0] by, input bit mid_eav,
                            input string tag);
        logic [9:0] v0, v;
        logic [15:0] m;
        bit hit;
        int off;
        off = ln - FL;
        m = odd ? mask_odd : mask_even;
        hit = (ln >= FL) && (off < 16) && m[off[3:0]] && valid;
        @(negedge clk);
        v0 = 10'($urandom);
        line_num = 10'(ln); field_odd = odd; data_valid = valid;
        wide_sel = wide; full_fmt = full; data_bytes = by;
        vid_in = v0; eav_end = 1'b1;
        @(negedge clk);
        if (hit) begin
            build(odd, wide, full, off[3:0], by);
            for (int k = 0; k < elen; k++) begin
                chk(vid_out, ew[k], tag);
                vid_in = 10'($urandom);
                eav_end = (mid_eav && k == 2);
                if (k < elen - 1) @(negedge clk);
            end
            @(negedge clk);
        end else begin
            chk(vid_out, v0, {tag, " R3 R4 no packet"});
            eav_end = 1'b0;
        end
        eav_end = 1'b0;
        for (int j = 0; j < 2; j++) begin
            v = 10'($urandom);
            vid_in = v;
            @(negedge clk);
            chk(vid_out, v, "R1 passthrough");
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(vid_out, 10'h000, "R12 reset output");
        eav_end = 1'b1; data_valid = 1'b1; mask_even = '1; line_num = 10'(FL);
        @(negedge clk);
        chk(vid_out, 10'h000, "R12 reset holds");
        eav_end = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        mask_even = 16'h8001; mask_odd = 16'h0002;
        run_line(FL, 0, 1, 0, 0, 32'h0000_A5C3, 0, "R2 R5 R8 R10 half 2B");
        run_line(FL, 0, 1, 1, 0, 32'h1234_5678, 0, "R7 R5 half 4B");
        run_line(FL, 0, 1, 1, 1, 32'hDEAD_BEEF, 0, "R6 R7 full 4B");
        run_line(FL, 0, 1, 0, 1, 32'h0000_FF01, 0, "R6 R9 full 2B");
        run_line(FL + 15, 0, 1, 0, 0, 32'h0000_3C3C, 0, "R3 mask bit15");
        run_line(FL + 16, 0, 1, 0, 0, 32'h0000_3C3C, 0, "R3 above window");
        run_line(FL - 1, 0, 1, 0, 0, 32'h0000_3C3C, 0, "R3 below window");
        run_line(FL, 1, 1, 0, 0, 32'h0000_1111, 0, "R3 odd mask off");
        run_line(FL + 1, 1, 1, 1, 0, 32'h8421_0F0F, 0, "R3 R9 odd mask on");
        run_line(FL, 0, 0, 0, 0, 32'h0000_7777, 0, "R4 data invalid");
        run_line(FL, 0, 1, 1, 0, 32'hCAFE_F00D, 1, "R11 eav mid packet");

        for (int n = 0; n < 60; n++) begin
            mask_even = 16'($urandom); mask_odd = 16'($urandom);
            run_line(FL - 2 + int'($urandom % 20), bit'($urandom), ($urandom % 5) != 0,
                     bit'($urandom), bit'($urandom), $urandom, ($urandom % 4) == 0,
                     "R2 R5 R6 R7 R8 R9 R10 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule